// File: doc/BRIEF.md
# LIN Response Byte Buffer with Checksum Engine

This block holds the data bytes of one LIN response frame and computes the frame checksum. A processor reaches the bytes through a single data port. A small selection register holds a 3-bit byte index and a hold bit. When the hold bit is clear, the index moves on by one after every data-port read or write and wraps from 7 back to 0. When the hold bit is set, the index stays where it is, so software must rewrite it before each access.

The serial side of the block works on its own byte counter. A transmit-response command makes the block present the stored bytes from index 0 upward, one per `tx_take` strobe, followed by the inverted checksum. A receive-response command stores incoming bytes from index 0 upward. It then adds the received checksum byte to the running sum and flags any result other than 0xFF. The sum is an 8-bit addition in which a carry out of bit 7 is added back into bit 0. The mode input is sampled when the command is issued: enhanced mode starts the sum from the protected identifier, and classic mode starts it from zero.

Top module: `lin_resp_buf`

## Requirements
- R1: After reset, `sel_rdata` reads 0 (index 0, hold bit 0), `busy` is 0, and `tx_done`, `rx_done` and `cks_err` are 0.
- R2: A data-port write stores `dat_wdata` in the byte selected by the index. While `dat_rd` is high, `dat_rdata` shows the byte that the current index selects.
- R3: With the hold bit (`sel_wdata[3]`) at 0, each cycle with `dat_wr` or `dat_rd` high advances the index by one, and index 7 wraps to 0.
- R4: With the hold bit at 1, data-port reads and writes leave the index unchanged.
- R5: After `cmd_tx`, `tx_byte` shows buffer bytes 0 to `len_m1` in order, one per `tx_take`, and then the checksum with `tx_is_cks` high. The `tx_take` of the checksum byte ends the response: the next cycle has a one-cycle `tx_done` pulse and `busy` low.
- R6: In classic mode (`mode_enh`=0), the transmitted checksum is the bitwise inverse of the end-around-carry sum of the data bytes alone.
- R7: In enhanced mode (`mode_enh`=1), the sum starts from `pid`. The mode is taken at the command, and changing `mode_enh` during the response has no effect.
- R8: After `cmd_rx`, received bytes are stored at indices 0, 1, and so on. Serial-side stores never move the software index.
- R9: The byte that follows the last data byte in receive mode is the checksum. If adding it to the running sum gives 0xFF, `rx_done` pulses for one cycle with `cks_err` low. Otherwise `cks_err` pulses for that same cycle.
- R10: If `sel_wr` and a data-port access fall in the same cycle, the access uses the old index and the index then takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Write strobe for the selection register |
| sel_wdata | input | 4 | Bit 3 hold (no auto-advance), bits 2:0 index |
| sel_rdata | output | 4 | Current hold bit and index |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_rdata | output | 8 | Byte at the current index |
| mode_enh | input | 1 | 1 enhanced checksum, 0 classic |
| pid | input | 8 | Protected identifier used in enhanced mode |
| len_m1 | input | 3 | Data length minus one (1 to 8 bytes) |
| cmd_tx | input | 1 | Start a transmit response |
| cmd_rx | input | 1 | Start a receive response |
| tx_take | input | 1 | Serial side consumes `tx_byte` |
| tx_byte | output | 8 | Byte offered to the serial side |
| tx_is_cks | output | 1 | `tx_byte` is the checksum |
| tx_done | output | 1 | One-cycle pulse when transmission ends |
| rx_valid | input | 1 | `rx_byte` carries a received byte |
| rx_byte | input | 8 | Received byte |
| rx_done | output | 1 | One-cycle pulse when reception ends |
| cks_err | output | 1 | One-cycle pulse on checksum mismatch |
| busy | output | 1 | A response is in progress |

## Verification
The bench fills all eight bytes so that the index has to wrap. A design with a wrong pointer width or without the wrap would leave `sel_rdata` at a value other than 0. Data bytes are chosen to produce carries out of bit 7, which exposes a sum that drops the end-around carry. During an enhanced transmission the bench flips `mode_enh`; a design that reads the mode live would send a different checksum. The receive tests check that the software index is left alone. They also send one frame with a corrupted checksum, which a design comparing the wrong value would miss.

// File: rtl/lin_buf_pkg.sv
package lin_buf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TX   = 2'd1,
        PH_RX   = 2'd2
    } phase_e;

    // 8-bit add with the carry out folded back into bit 0
    function automatic logic [BYTE_W-1:0] eac_add(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
    endfunction

endpackage

// File: rtl/lin_idx_ctrl.sv
module lin_idx_ctrl #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             sel_hold,
    input  logic             acc,
    output logic [IDX_W-1:0] idx,
    output logic             hold
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.idx  = sel_idx;
            st_d.hold = sel_hold;
        end else if (acc && !st_q.hold) begin
            st_d.idx = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx  = st_q.idx;
    assign hold = st_q.hold;

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_wr && acc && !hold && idx == {IDX_W{1'b1}}) |=> (idx == '0)); // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_wr && hold) |=> $stable(idx)); // R4
    AST_SEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && acc) |=> (idx == $past(sel_idx))); // R10
endmodule

// File: rtl/lin_byte_store.sv
module lin_byte_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [W-1:0]  cpu_wdata,
    output logic [W-1:0]  cpu_rdata,
    input  logic          ser_we,
    input  logic [AW-1:0] ser_addr,
    input  logic [W-1:0]  ser_wdata,
    output logic [W-1:0]  ser_rdata
);
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (ser_we && ser_addr == AW'(i))
                mem_d[i] = ser_wdata;
            else if (cpu_we && cpu_addr == AW'(i))
                mem_d[i] = cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign cpu_rdata = mem_q[cpu_addr];
    assign ser_rdata = mem_q[ser_addr];

    AST_SER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_we |=> (mem_q[$past(ser_addr)] == $past(ser_wdata))); // R8
    AST_CPU_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !(ser_we && ser_addr == cpu_addr)) |=> (mem_q[$past(cpu_addr)] == $past(cpu_wdata))); // R2
endmodule

// File: rtl/lin_cksum_unit.sv
module lin_cksum_unit
    import lin_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [BYTE_W-1:0] clr_val,
    input  logic              add,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [BYTE_W-1:0] sum
);
    typedef struct packed {
        logic [BYTE_W-1:0] sum;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)      st_d.sum = clr_val;
        else if (add) st_d.sum = eac_add(st_q.sum, add_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.sum;

    AST_SUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add) |=> $stable(sum)); // R6
endmodule

// File: rtl/lin_resp_seq.sv
module lin_resp_seq
    import lin_buf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_tx,
    input  logic              cmd_rx,
    input  logic              mode_enh,
    input  logic [BYTE_W-1:0] pid,
    input  logic [AW-1:0]     len_m1,
    input  logic              tx_take,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] buf_rdata,
    input  logic [BYTE_W-1:0] sum,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_we,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              ck_clr,
    output logic [BYTE_W-1:0] ck_clr_val,
    output logic              ck_add,
    output logic [BYTE_W-1:0] ck_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_is_cks,
    output logic              tx_done,
    output logic              rx_done,
    output logic              cks_err,
    output logic              busy
);
    typedef struct packed {
        phase_e        phase;
        logic [PW-1:0] pos;
        logic [AW-1:0] len;
        logic          tx_done;
        logic          rx_done;
        logic          cks_err;
    } st_t;

    st_t  st_d, st_q;
    logic in_data;

    always_comb begin
        st_d         = st_q;
        st_d.tx_done = 1'b0;
        st_d.rx_done = 1'b0;
        st_d.cks_err = 1'b0;
        in_data      = (st_q.pos <= {1'b0, st_q.len});
        buf_addr     = st_q.pos[AW-1:0];
        buf_we       = 1'b0;
        buf_wdata    = rx_byte;
        ck_clr       = 1'b0;
        ck_clr_val   = mode_enh ? pid : '0;
        ck_add       = 1'b0;
        ck_byte      = buf_rdata;
        tx_byte      = in_data ? buf_rdata : ~sum;
        tx_is_cks    = (st_q.phase == PH_TX) && !in_data;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_tx || cmd_rx) begin
                    st_d.phase = cmd_tx ? PH_TX : PH_RX;
                    st_d.pos   = '0;
                    st_d.len   = len_m1;
                    ck_clr     = 1'b1;
                end
            end
            PH_TX: begin
                if (tx_take) begin
                    if (in_data) begin
                        ck_add   = 1'b1;
                        st_d.pos = st_q.pos + PW'(1);
                    end else begin
                        st_d.phase   = PH_IDLE;
                        st_d.tx_done = 1'b1;
                    end
                end
            end
            PH_RX: begin
                ck_byte = rx_byte;
                if (rx_valid) begin
                    if (in_data) begin
                        buf_we   = 1'b1;
                        ck_add   = 1'b1;
                        st_d.pos = st_q.pos + PW'(1);
                    end else begin
                        st_d.phase   = PH_IDLE;
                        st_d.rx_done = 1'b1;
                        st_d.cks_err = (eac_add(sum, rx_byte) != {BYTE_W{1'b1}});
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_IDLE;
            st_q.pos     <= '0;
            st_q.len     <= '0;
            st_q.tx_done <= 1'b0;
            st_q.rx_done <= 1'b0;
            st_q.cks_err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_done = st_q.tx_done;
    assign rx_done = st_q.rx_done;
    assign cks_err = st_q.cks_err;
    assign busy    = (st_q.phase != PH_IDLE);

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cks_err |=> !cks_err); // R9
    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        cks_err |-> rx_done); // R9
    AST_TX_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !busy); // R5
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_done && !rx_done) |=> (busy ? $stable(st_q.len) : 1'b1)); // R7
endmodule

// File: rtl/lin_resp_buf.sv
module lin_resp_buf
    import lin_buf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [AW:0]       sel_wdata,
    output logic [AW:0]       sel_rdata,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] dat_wdata,
    output logic [BYTE_W-1:0] dat_rdata,
    input  logic              mode_enh,
    input  logic [BYTE_W-1:0] pid,
    input  logic [AW-1:0]     len_m1,
    input  logic              cmd_tx,
    input  logic              cmd_rx,
    input  logic              tx_take,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_is_cks,
    output logic              tx_done,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done,
    output logic              cks_err,
    output logic              busy
);
    logic [AW-1:0]     idx;
    logic              hold;
    logic [AW-1:0]     ser_addr;
    logic              ser_we;
    logic [BYTE_W-1:0] ser_wdata;
    logic [BYTE_W-1:0] ser_rdata;
    logic              ck_clr;
    logic [BYTE_W-1:0] ck_clr_val;
    logic              ck_add;
    logic [BYTE_W-1:0] ck_byte;
    logic [BYTE_W-1:0] sum;

    lin_idx_ctrl #(.IDX_W(AW)) u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_idx  (sel_wdata[AW-1:0]),
        .sel_hold (sel_wdata[AW]),
        .acc      (dat_wr || dat_rd),
        .idx      (idx),
        .hold     (hold)
    );

    lin_byte_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (dat_wr),
        .cpu_addr  (idx),
        .cpu_wdata (dat_wdata),
        .cpu_rdata (dat_rdata),
        .ser_we    (ser_we),
        .ser_addr  (ser_addr),
        .ser_wdata (ser_wdata),
        .ser_rdata (ser_rdata)
    );

    lin_cksum_unit u_cks (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ck_clr),
        .clr_val  (ck_clr_val),
        .add      (ck_add),
        .add_byte (ck_byte),
        .sum      (sum)
    );

    lin_resp_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_tx     (cmd_tx),
        .cmd_rx     (cmd_rx),
        .mode_enh   (mode_enh),
        .pid        (pid),
        .len_m1     (len_m1),
        .tx_take    (tx_take),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .buf_rdata  (ser_rdata),
        .sum        (sum),
        .buf_addr   (ser_addr),
        .buf_we     (ser_we),
        .buf_wdata  (ser_wdata),
        .ck_clr     (ck_clr),
        .ck_clr_val (ck_clr_val),
        .ck_add     (ck_add),
        .ck_byte    (ck_byte),
        .tx_byte    (tx_byte),
        .tx_is_cks  (tx_is_cks),
        .tx_done    (tx_done),
        .rx_done    (rx_done),
        .cks_err    (cks_err),
        .busy       (busy)
    );

    assign sel_rdata = {hold, idx};

    AST_SER_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !sel_wr && !dat_wr && !dat_rd) |=> $stable(sel_rdata)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R9
endmodule

// File: tb/lin_resp_buf_test.sv
module lin_resp_buf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 0, dat_wr = 0, dat_rd = 0, mode_enh = 0;
    logic [3:0] sel_wdata = '0;
    logic [3:0] sel_rdata;
    logic [7:0] dat_wdata = '0, dat_rdata, pid = '0, tx_byte, rx_byte = '0;
    logic [2:0] len_m1 = '0;
    logic       cmd_tx = 0, cmd_rx = 0, tx_take = 0, rx_valid = 0;
    logic       tx_is_cks, tx_done, rx_done, cks_err, busy;

    int total = 0;
    int bad   = 0;
    logic [7:0] mdl [8];
    logic [2:0] e_idx  = '0;
    logic       e_hold = 1'b0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    lin_resp_buf uut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .sel_rdata(sel_rdata), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .mode_enh(mode_enh),
        .pid(pid), .len_m1(len_m1), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx),
        .tx_take(tx_take), .tx_byte(tx_byte), .tx_is_cks(tx_is_cks),
        .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_done(rx_done), .cks_err(cks_err), .busy(busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] add_fold(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] t;
        t = a + b;
        if (t > 9'h0FF) t = t - 9'h0FF;
        return t[7:0];
    endfunction

    function automatic logic [7:0] frame_cks(input logic enh, input logic [7:0] id, input int n);
        logic [7:0] s;
        s = enh ? id : 8'h00;
        for (int i = 0; i < n; i++) s = add_fold(s, mdl[i]);
        return ~s;
    endfunction

    // monitor: pops the scoreboard on every consumed transmit byte (R5)
    always @(negedge clk) begin
        if (tx_take) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R5 unexpected tx byte actual=%0h expected=none", tx_byte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (tx_byte !== e) begin
                    bad++;
                    $display("FAIL R5/R6/R7 tx byte actual=%0h expected=%0h", tx_byte, e);
                end
            end
        end
    end

    task automatic sel_write(input logic hold_b, input logic [2:0] ix);
        @(posedge clk); #2 sel_wr = 1; sel_wdata = {hold_b, ix};
        @(posedge clk); #2 sel_wr = 0;
        e_idx = ix; e_hold = hold_b;
    endtask

    task automatic dat_write(input logic [7:0] b);
        @(posedge clk); #2 dat_wr = 1; dat_wdata = b;
        @(posedge clk); #2 dat_wr = 0;
        mdl[e_idx] = b;
        if (!e_hold) e_idx = e_idx + 3'd1;
    endtask

    task automatic dat_read(input string req);
        @(posedge clk); #2 dat_rd = 1;
        @(negedge clk); chk(req, dat_rdata, mdl[e_idx]);
        @(posedge clk); #2 dat_rd = 0;
        if (!e_hold) e_idx = e_idx + 3'd1;
    endtask

    task automatic tx_frame(input logic enh, input logic [7:0] id, input logic [2:0] lm1);
        @(posedge clk); #2 cmd_tx = 1; mode_enh = enh; pid = id; len_m1 = lm1;
        @(posedge clk); #2 cmd_tx = 0;
        for (int i = 0; i <= int'(lm1); i++) exp_q.push_back(mdl[i]);
        exp_q.push_back(frame_cks(enh, id, int'(lm1) + 1));
        for (int i = 0; i <= int'(lm1) + 1; i++) begin
            @(posedge clk); #2 tx_take = 1;
            if (i == 0) mode_enh = ~enh; // R7: late mode change must be ignored
            @(negedge clk);
            if (i == int'(lm1) + 1) chk("R5 tx_is_cks on checksum", {7'd0, tx_is_cks}, 8'd1);
            @(posedge clk); #2 tx_take = 0;
        end
        @(negedge clk);
        chk("R5 tx_done pulse", {7'd0, tx_done}, 8'd1);
        chk("R5 busy low after tx", {7'd0, busy}, 8'd0);
        chk("R5 scoreboard drained", 8'(exp_q.size()), 8'd0);
    endtask

    task automatic rx_frame(input logic enh, input logic [7:0] id, input logic [2:0] lm1,
                            input logic [7:0] seed, input logic [7:0] corrupt);
        logic [3:0] sel_before;
        sel_before = sel_rdata;
        @(posedge clk); #2 cmd_rx = 1; mode_enh = enh; pid = id; len_m1 = lm1;
        @(posedge clk); #2 cmd_rx = 0;
        for (int i = 0; i <= int'(lm1) + 1; i++) begin
            logic [7:0] b;
            if (i <= int'(lm1)) begin
                b = seed + 8'(i * 61);
                mdl[i] = b;
            end else begin
                b = frame_cks(enh, id, int'(lm1) + 1) ^ corrupt;
            end
            @(posedge clk); #2 rx_valid = 1; rx_byte = b;
            @(posedge clk); #2 rx_valid = 0;
        end
        @(negedge clk);
        chk("R9 rx_done pulse", {7'd0, rx_done}, 8'd1);
        chk("R9 cks_err value", {7'd0, cks_err}, {7'd0, (corrupt != 8'h00)});
        chk("R8 software index untouched", {4'd0, sel_rdata}, {4'd0, sel_before});
        @(negedge clk);
        chk("R9 cks_err one cycle", {7'd0, cks_err}, 8'd0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk("R1 sel_rdata reset", {4'd0, sel_rdata}, 8'd0);
        chk("R1 busy reset", {7'd0, busy}, 8'd0);
        chk("R1 pulses reset", {5'd0, tx_done, rx_done, cks_err}, 8'd0);

        // R3: eight writes with auto-advance wrap back to index 0
        sel_write(1'b0, 3'd0);
        dat_write(8'hF0); dat_write(8'h35); dat_write(8'h80); dat_write(8'hC7);
        dat_write(8'h9A); dat_write(8'hFF); dat_write(8'h12); dat_write(8'hE4);
        @(negedge clk); chk("R3 index wrapped to 0", {4'd0, sel_rdata}, 8'd0);

        // R2: read back all bytes in order
        for (int i = 0; i < 8; i++) dat_read("R2 read back");
        @(negedge clk); chk("R3 index after 8 reads", {4'd0, sel_rdata}, 8'd0);

        // R4: hold bit keeps the index
        sel_write(1'b1, 3'd5);
        dat_write(8'hAA);
        dat_read("R4 read with hold");
        @(negedge clk); chk("R4 index held", {4'd0, sel_rdata}, 8'h0D);

        // R10: selection write in the same cycle as a data write
        sel_write(1'b0, 3'd6);
        @(posedge clk); #2 dat_wr = 1; dat_wdata = 8'h3C; sel_wr = 1; sel_wdata = 4'd2;
        @(posedge clk); #2 dat_wr = 0; sel_wr = 0;
        mdl[6] = 8'h3C; e_idx = 3'd2; e_hold = 1'b0;
        @(negedge clk); chk("R10 selection write wins", {4'd0, sel_rdata}, 8'd2);
        sel_write(1'b0, 3'd6);
        dat_read("R10 data went to old index");

        // R5/R6: classic transmit, four bytes with carries
        tx_frame(1'b0, 8'h00, 3'd3);
        // R7: enhanced transmit, all eight bytes, mode flipped mid-frame
        tx_frame(1'b1, 8'h97, 3'd7);
        // R6: single-byte classic frame
        tx_frame(1'b0, 8'h3C, 3'd0);

        // R8/R9: receive frames
        sel_write(1'b1, 3'd4);
        rx_frame(1'b0, 8'h00, 3'd2, 8'hD1, 8'h00);
        rx_frame(1'b1, 8'h42, 3'd7, 8'hB7, 8'h00);
        rx_frame(1'b1, 8'h42, 3'd4, 8'h5E, 8'h01);
        sel_write(1'b0, 3'd0);
        for (int i = 0; i < 8; i++) dat_read("R8 received byte stored");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule